// File: doc/BRIEF.md
# Four-Region Trace Ring Writer

This block turns a stream of 32-bit trace words into write commands for memory. Software programs four region base addresses and one shared region size. While tracing is on, each accepted word gets the next word address in the current region. When a region is full, the block moves to the next region in the fixed order 0, 1, 2, 3. After region 3 it goes back to region 0, but only if tracing is still on.

When the final word of a region is written, a one-cycle completion pulse carries that region's index, so software knows which region to drain. When tracing is switched off, the block keeps writing until the word that closes the current record. It then stops and holds its region index and word offset on its outputs. Turning tracing on again starts over at region 0, offset 0.

The region size is given in bytes. A size of zero selects the default of 4 MiB. Any size below one word still holds one word.

Top module: `trace_ring_writer`

## Requirements
- R1: After reset, `tracing`, `wr_valid` and `done_valid` are 0, and `cur_idx` and `cur_off` are 0.
- R2: While `tracing` is 0, input words produce no write command. A cycle in which `trace_en` is 1 while idle sets `tracing` to 1 at index 0, offset 0 from the next cycle on.
- R3: A word accepted while tracing (`in_valid`=1) appears one cycle later on `wr_valid`/`wr_data`. Its `wr_addr` equals the base of the current region plus 4 times the current word offset, and the offset then grows by one.
- R4: Regions fill strictly in the order 0, 1, 2, 3. After a region's last word, the index moves to the next region and the offset goes back to 0.
- R5: Writing the last word of a region raises `done_valid` for exactly one cycle, in the same cycle as that word's write command, with `done_idx` equal to that region's index.
- R6: After region 3 completes while `trace_en` is 1, writing continues at region 0, offset 0, with no idle cycle.
- R7: With `trace_en` at 0, words are still written until one with `in_last`=1 is written, and then `tracing` drops. While idle with `trace_en` at 0, `cur_idx` and `cur_off` hold their values.
- R8: If region 3 completes while `trace_en` is 0, tracing stops with `cur_idx`=0 and `cur_off`=0, even without a record end.
- R9: The region holds `buf_size`/4 words. A `buf_size` of 0 means 4 MiB (1,048,576 words), and a `buf_size` from 1 to 3 means one word.
- R10: Raising `trace_en` again after a stop restarts at region 0, offset 0, whatever position was held.
- R11: A tracing cycle with `in_valid`=0 produces no write and leaves the offset and index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trace_en | input | 1 | Tracing request from software |
| base0 | input | 32 | Byte base address of region 0 |
| base1 | input | 32 | Byte base address of region 1 |
| base2 | input | 32 | Byte base address of region 2 |
| base3 | input | 32 | Byte base address of region 3 |
| buf_size | input | 32 | Region size in bytes; 0 selects 4 MiB |
| in_valid | input | 1 | Trace word present this cycle |
| in_data | input | 32 | Trace word |
| in_last | input | 1 | Word closes a record |
| wr_valid | output | 1 | Write command valid |
| wr_addr | output | 32 | Byte address of the write |
| wr_data | output | 32 | Data of the write |
| done_valid | output | 1 | One-cycle region completion pulse |
| done_idx | output | 2 | Index of the completed region |
| tracing | output | 1 | Writer is active |
| cur_idx | output | 2 | Current region index |
| cur_off | output | 30 | Current word offset in the region |

## Verification
The bench drives gaps in the input stream, and a design that advanced on idle cycles would skip addresses. It runs five regions in a row to check the wrap from region 3 back to region 0; a design that got this wrong would stall or run into a fifth base. Tracing is switched off in the middle of a record, so a design that stopped at once would lose the tail of that record. Tracing is also switched off just before region 3 fills, so a design that wrapped anyway would keep writing into region 0. Finally, the sizes 0 and 2 exercise the default-size and sub-word rules, where a design with a bad word count would pulse done too early or would never pulse it.

// File: rtl/trw_pkg.sv
package trw_pkg;
  localparam int NBUF  = 4;
  localparam int IDX_W = $clog2(NBUF);
  typedef logic [IDX_W-1:0] buf_idx_t;

  function automatic buf_idx_t next_idx(input buf_idx_t i);
    return buf_idx_t'(i + buf_idx_t'(1));
  endfunction

  function automatic logic is_final_region(input buf_idx_t i);
    return i == buf_idx_t'(NBUF - 1);
  endfunction
endpackage

// File: rtl/trw_seq.sv
module trw_seq
  import trw_pkg::*;
#(
  parameter int SIZE_W    = 32,
  parameter int DEF_BYTES = 4 * 1024 * 1024,
  localparam int OFF_W    = SIZE_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [SIZE_W-1:0] size_bytes,
  output logic             active,
  output buf_idx_t         cur_idx,
  output logic [OFF_W-1:0] cur_off,
  output logic             accept,
  output logic             buf_end
);
  // number of words a region holds, with the zero and sub-word rules
  function automatic logic [OFF_W-1:0] region_words(input logic [SIZE_W-1:0] sz);
    logic [OFF_W-1:0] w;
    w = sz[SIZE_W-1:2];
    if (sz == '0)      w = OFF_W'(DEF_BYTES / 4);
    else if (w == '0)  w = OFF_W'(1);
    return w;
  endfunction

  logic [OFF_W-1:0] last_off;
  logic             stop_rec;
  logic             stop_ring;

  assign last_off  = region_words(size_bytes) - OFF_W'(1);
  assign accept    = active && in_valid;
  assign buf_end   = accept && (cur_off >= last_off);
  assign stop_rec  = accept && !enable && in_last;
  assign stop_ring = buf_end && is_final_region(cur_idx) && !enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cur_idx <= '0;
      cur_off <= '0;
    end else if (!active) begin
      if (enable) begin
        active  <= 1'b1;
        cur_idx <= '0;
        cur_off <= '0;
      end
    end else if (accept) begin
      if (buf_end) begin
        cur_off <= '0;
        cur_idx <= next_idx(cur_idx);
      end else begin
        cur_off <= cur_off + OFF_W'(1);
      end
      if (stop_rec || stop_ring) active <= 1'b0;
    end
  end

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !enable) |=> ($stable(cur_idx) && $stable(cur_off)));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && enable) |=> (active && cur_idx == '0 && cur_off == '0));
  p_off_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !buf_end) |=> (cur_off == $past(cur_off) + OFF_W'(1)));
  p_gap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !in_valid) |=> ($stable(cur_idx) && $stable(cur_off)));
endmodule

// File: rtl/trw_emit.sv
module trw_emit
  import trw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 30
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NBUF-1:0][ADDR_W-1:0] bases,
  input  logic                        accept,
  input  logic                        buf_end,
  input  buf_idx_t                    idx,
  input  logic [OFF_W-1:0]            off,
  input  logic [DATA_W-1:0]           data,
  output logic                        wr_valid,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [DATA_W-1:0]           wr_data,
  output logic                        done_valid,
  output buf_idx_t                    done_idx
);
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [OFF_W-1:0]  o);
    return base + ADDR_W'({o, 2'b00});
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done_valid <= 1'b0;
      done_idx   <= '0;
    end else begin
      wr_valid   <= accept;
      done_valid <= buf_end;
      if (accept) begin
        wr_addr <= word_addr(bases[idx], off);
        wr_data <= data;
      end
      if (buf_end) done_idx <= idx;
    end
  end

  p_no_write_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !wr_valid);
  p_done_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !buf_end) |=> !done_valid);
endmodule

// File: rtl/trace_ring_writer.sv
module trace_ring_writer
  import trw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 32,
  parameter int DEF_BYTES = 4 * 1024 * 1024,
  localparam int OFF_W    = SIZE_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] base1,
  input  logic [ADDR_W-1:0] base2,
  input  logic [ADDR_W-1:0] base3,
  input  logic [SIZE_W-1:0] buf_size,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done_valid,
  output logic [IDX_W-1:0]  done_idx,
  output logic              tracing,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [OFF_W-1:0]  cur_off
);
  logic [NBUF-1:0][ADDR_W-1:0] bases;
  logic [ADDR_W-1:0]           base_list [NBUF];
  logic                        accept;
  logic                        buf_end;
  buf_idx_t                    idx_w;
  buf_idx_t                    didx_w;

  assign base_list[0] = base0;
  assign base_list[1] = base1;
  assign base_list[2] = base2;
  assign base_list[3] = base3;

  for (genvar g = 0; g < NBUF; g++) begin : g_base
    assign bases[g] = base_list[g];
  end

  trw_seq #(.SIZE_W(SIZE_W), .DEF_BYTES(DEF_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(trace_en), .in_valid(in_valid),
    .in_last(in_last), .size_bytes(buf_size), .active(tracing),
    .cur_idx(idx_w), .cur_off(cur_off), .accept(accept), .buf_end(buf_end)
  );

  trw_emit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .bases(bases), .accept(accept),
    .buf_end(buf_end), .idx(idx_w), .off(cur_off), .data(in_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_valid(done_valid), .done_idx(didx_w)
  );

  assign cur_idx  = idx_w;
  assign done_idx = didx_w;

  p_done_with_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> wr_valid);
  p_done_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (cur_off == '0));
  p_done_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (idx_w == next_idx(didx_w)));
endmodule

// File: tb/trace_ring_writer_test.sv
module trace_ring_writer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        trace_en = 0;
  logic [31:0] base0 = 32'h1000_0000, base1 = 32'h2000_0100;
  logic [31:0] base2 = 32'h3000_0200, base3 = 32'h4000_0300;
  logic [31:0] buf_size = 32'd16;
  logic        in_valid = 0, in_last = 0;
  logic [31:0] in_data = 0;
  logic        wr_valid, done_valid, tracing;
  logic [31:0] wr_addr, wr_data;
  logic [1:0]  done_idx, cur_idx;
  logic [29:0] cur_off;

  trace_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .base0(base0), .base1(base1),
    .base2(base2), .base3(base3), .buf_size(buf_size), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .done_valid(done_valid), .done_idx(done_idx),
    .tracing(tracing), .cur_idx(cur_idx), .cur_off(cur_off)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, writes = 0, cyc = 0;
  int dq[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  bit     m_act = 0, e_wv = 0, e_dv = 0;
  int     m_idx = 0;
  longint m_off = 0;
  int     e_didx = 0;
  longint e_addr = 0, e_data = 0;

  function automatic longint words_of(input logic [31:0] s);
    if (s == 0) return 64'd1048576;
    if (s < 4)  return 1;
    return longint'(s) / 4;
  endfunction

  function automatic longint base_of(input int i);
    case (i)
      0: return base0;
      1: return base1;
      2: return base2;
      default: return base3;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_idx = 0; m_off = 0; e_wv = 0; e_dv = 0;
    end else begin
      e_wv = 0; e_dv = 0;
      if (!m_act) begin
        if (trace_en) begin m_act = 1; m_idx = 0; m_off = 0; end
      end else if (in_valid) begin
        e_wv = 1;
        e_addr = (base_of(m_idx) + m_off * 4) & 64'hFFFF_FFFF;
        e_data = in_data;
        if (m_off == words_of(buf_size) - 1) begin
          e_dv = 1; e_didx = m_idx; m_off = 0;
          if (m_idx == 3) begin m_idx = 0; if (!trace_en) m_act = 0; end
          else m_idx++;
        end else m_off++;
        if (!trace_en && in_last) m_act = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(wr_valid == e_wv, "R3 wr_valid", wr_valid, e_wv);
      if (e_wv) begin
        check(wr_addr == e_addr[31:0], "R3 wr_addr", wr_addr, e_addr);
        check(wr_data == e_data[31:0], "R3 wr_data", wr_data, e_data);
      end
      check(done_valid == e_dv, "R5 done_valid", done_valid, e_dv);
      if (e_dv) check(done_idx == e_didx, "R5 done_idx", done_idx, e_didx);
      check(tracing == m_act, "R7 tracing", tracing, m_act);
      check(cur_idx == m_idx, "R4 cur_idx", cur_idx, m_idx);
      check(cur_off == m_off, "R11 cur_off", cur_off, m_off);
      if (wr_valid) writes++;
      if (done_valid) dq.push_back(done_idx);
    end
  end

  task automatic word(input logic [31:0] d, input bit last);
    @(negedge clk);
    in_valid = 1; in_data = d; in_last = last;
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w0;
    idle(3);
    check(tracing == 0 && wr_valid == 0 && done_valid == 0, "R1 outputs", tracing, 0);
    check(cur_idx == 0 && cur_off == 0, "R1 position", cur_off, 0);
    rst_n = 1;
    idle(1);
    // R2: words while idle are dropped
    w0 = writes;
    word(32'hAAAA_0001, 0); word(32'hAAAA_0002, 1);
    idle(1);
    check(writes == w0, "R2 idle writes", writes, w0);
    // R4 R6 R11: five regions with gaps
    @(negedge clk); trace_en = 1;
    idle(1);
    check(tracing == 1 && cur_idx == 0 && cur_off == 0, "R2 start", tracing, 1);
    dq.delete();
    for (int i = 0; i < 20; i++) begin
      word(32'hB000_0000 + i, (i % 3) == 2);
      if (i % 4 == 1) idle(2);
    end
    idle(1);
    check(dq.size() == 5, "R4 done count", dq.size(), 5);
    if (dq.size() == 5) begin
      check(dq[0] == 0 && dq[1] == 1 && dq[2] == 2 && dq[3] == 3, "R4 order", dq[3], 3);
      check(dq[4] == 0, "R6 wrap to region 0", dq[4], 0);
    end
    // R7: disable mid-record, writes continue until record end
    word(32'hC000_0001, 0);
    @(negedge clk); trace_en = 0;
    w0 = writes;
    word(32'hC000_0002, 0); word(32'hC000_0003, 0);
    check(tracing == 1, "R7 still tracing", tracing, 1);
    word(32'hC000_0004, 1);
    idle(1);
    check(writes == w0 + 3, "R7 tail written", writes, w0 + 3);
    check(tracing == 0, "R7 stopped", tracing, 0);
    check(cur_idx == 2 && cur_off == 0, "R7 held position", cur_idx, 2);
    w0 = writes;
    word(32'hC000_0005, 1); idle(2);
    check(writes == w0 && cur_idx == 2, "R7 idle ignore", writes, w0);
    // R10: restart at 0/0
    @(negedge clk); trace_en = 1;
    idle(1);
    check(cur_idx == 0 && cur_off == 0 && tracing == 1, "R10 restart", cur_idx, 0);
    // R8: region 3 completes with enable low
    for (int i = 0; i < 15; i++) word(32'hD000_0000 + i, 0);
    check(cur_idx == 3 && cur_off == 3, "R8 setup", cur_off, 3);
    @(negedge clk); trace_en = 0;
    word(32'hD000_00FF, 0);
    idle(1);
    check(tracing == 0 && cur_idx == 0 && cur_off == 0, "R8 stop at ring end", tracing, 0);
    // R9: sub-word size
    buf_size = 32'd2;
    @(negedge clk); trace_en = 1; idle(1);
    dq.delete();
    for (int i = 0; i < 3; i++) word(32'hE000_0000 + i, 0);
    idle(1);
    check(dq.size() == 3, "R9 one-word regions", dq.size(), 3);
    // R9: default size
    @(negedge clk); trace_en = 0; word(32'hE000_00FF, 1);
    buf_size = 32'd0;
    @(negedge clk); trace_en = 1; idle(1);
    dq.delete();
    for (int i = 0; i < 100; i++) word(32'hF000_0000 + i, 0);
    idle(1);
    check(dq.size() == 0 && cur_idx == 0 && cur_off == 100, "R9 default size", cur_off, 100);
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule